// File: doc/BRIEF.md
# TLB Victim Index Picker

This block chooses which translation buffer slot to overwrite when a new mapping must be installed and no free slot is known. It keeps a 32-bit linear congruential state. Each accepted request steps that state once. The upper half of the new state is then folded into the span of replaceable slots. Slots below the locked-entry count are pinned, so they are never returned.

The caller raises a one-cycle request strobe and supplies two values: the total slot count and the number of pinned slots. Both are captured when the request is accepted. The remainder is computed by a bit-serial restoring divider, one dividend bit per clock. The chosen index then appears together with a one-cycle valid pulse. While the divider runs, further strobes are dropped. The divider has no side path, so every request takes the same number of cycles, including the case where every slot is pinned.

Top module: `tlb_victim_sel`

## Requirements
- R1: After reset the state is zero and valid_o is low. The first accepted request therefore yields state 1 and raw value 0, so its index equals the captured pinned count.
- R2: Each accepted request replaces the state with state × 314159 + 1, keeping the low 32 bits.
- R3: The raw value is bits 31..16 of the new state, that is, the new state shifted right by 16.
- R4: When pinned_i < slots_i, the index is (raw mod (slots − pinned)) + pinned. It always lies between pinned and slots − 1 inclusive.
- R5: valid_o is high for exactly one cycle. It rises after the 16th rising edge that follows the edge accepting the request. While valid_o is low, index_o reads 0.
- R6: A request is accepted only when no computation is in flight. A strobe during a computation produces no extra valid pulse and does not advance the state.
- R7: When pinned_i ≥ slots_i, the index is slots − 1 taken modulo 64. No division by zero affects the result.
- R8: slots_i and pinned_i are sampled at acceptance. Changing them during a computation does not alter that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe for a new victim index |
| slots_i | input | 7 | Total slot count, 1 to 64 |
| pinned_i | input | 6 | Number of locked low slots |
| index_o | output | 6 | Chosen slot index, 0 when not valid |
| valid_o | output | 1 | One-cycle pulse marking index_o |

## Verification
The hardest conditions to reach from the ports are a strobe that arrives while the divider is busy and input values that change in the middle of a computation. Either one can be wrong without any visible sign unless the index sequence that follows is compared against a model. For that reason the stimulus does two things during the busy window: it raises a second strobe and it scrambles the slot and pinned inputs. The model steps its state only for accepted requests. Any state advance that should not have happened then shows up as a mismatched index in the next result. The stimulus also covers the fully pinned and over-pinned cases, and a run of varied spans, including a span of one.

// File: rtl/tlbrand_pkg.sv
// Shared constants for the victim index picker.
// Assumes a 32-bit congruential state and a 64-slot maximum buffer.
package tlbrand_pkg;
    localparam int unsigned LCG_MUL    = 314159;
    localparam int unsigned LCG_INC    = 1;
    localparam int unsigned STATE_BITS = 32;
    localparam int unsigned RAW_SHIFT  = 16;
    localparam int unsigned IDX_BITS   = 6;
endpackage

// File: rtl/tlbrand_lcg.sv
// One step of the linear congruential generator: nxt = state*MUL + INC,
// truncated to STATE_W bits. Purely combinational.
module tlbrand_lcg #(
    parameter int unsigned STATE_W = 32,
    parameter int unsigned MUL     = 314159,
    parameter int unsigned INC     = 1
) (
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] next_o
);
    localparam logic [STATE_W-1:0] MUL_V = STATE_W'(MUL);
    localparam logic [STATE_W-1:0] INC_V = STATE_W'(INC);

    // Multiply-add in modular arithmetic of the state width.
    always_comb begin
        next_o = state_i * MUL_V + INC_V;
    end
endmodule

// File: rtl/tlbrand_rdiv.sv
// Bit-serial restoring remainder unit. It takes DVD_W cycles after start and
// pulses done_o. Assumes that remainders below divisor fit in DSR_W-1 bits.
// A zero divisor gives a meaningless remainder, which the caller discards.
module tlbrand_rdiv #(
    parameter int unsigned DVD_W = 16,
    parameter int unsigned DSR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DSR_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DSR_W-1:0] rem_o
);
    localparam int unsigned CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DSR_W-1:0] dsr_q;
    logic [DSR_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DSR_W-1:0] trial;
    logic [DSR_W-1:0] rem_nx;

    // Shift in the next dividend bit and subtract the divisor if it fits.
    always_comb begin
        trial  = {rem_q[DSR_W-2:0], dvd_q[DVD_W-1]};
        rem_nx = (trial >= dsr_q) ? (trial - dsr_q) : trial;
    end

    // Load on start, then run one iteration per clock until the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            dsr_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                dvd_q  <= dividend_i;
                dsr_q  <= divisor_i;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_nx;
                dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign rem_o  = rem_q;
endmodule

// File: rtl/tlb_victim_sel.sv
// Victim index picker for a translation buffer. On an accepted request it
// steps the congruential state and captures the slot and pinned counts. It
// then reduces the upper state half modulo the unpinned span and offsets the
// result by the pinned count. Assumes 1 <= slots_i <= 2**IDX_W. When every
// slot is pinned, the index falls back to slots-1.
module tlb_victim_sel
    import tlbrand_pkg::*;
#(
    parameter int unsigned STATE_W = STATE_BITS,
    parameter int unsigned SHIFT   = RAW_SHIFT,
    parameter int unsigned IDX_W   = IDX_BITS,
    parameter int unsigned MUL     = LCG_MUL,
    parameter int unsigned INC     = LCG_INC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W:0]   slots_i,
    input  logic [IDX_W-1:0] pinned_i,
    output logic [IDX_W-1:0] index_o,
    output logic             valid_o
);
    localparam int unsigned CNT_W = IDX_W + 1;
    localparam int unsigned RAW_W = STATE_W - SHIFT;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_nx;
    logic [CNT_W-1:0]   slots_q;
    logic [IDX_W-1:0]   pinned_q;
    logic [CNT_W-1:0]   span;
    logic [CNT_W-1:0]   rem;
    logic [CNT_W-1:0]   top_slot;
    logic               busy;
    logic               done;
    logic               accept;
    logic               all_pinned;

    tlbrand_lcg #(.STATE_W(STATE_W), .MUL(MUL), .INC(INC)) lcg_i (
        .state_i (state_q),
        .next_o  (state_nx)
    );

    // A request is taken only while the divider is idle.
    always_comb begin
        accept = req_i && !busy;
        span   = slots_i - {1'b0, pinned_i};
    end

    tlbrand_rdiv #(.DVD_W(RAW_W), .DSR_W(CNT_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .dividend_i (state_nx[STATE_W-1:SHIFT]),
        .divisor_i  (span),
        .busy_o     (busy),
        .done_o     (done),
        .rem_o      (rem)
    );

    // Advance the generator and capture the range inputs on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= '0;
            slots_q  <= '0;
            pinned_q <= '0;
        end else if (accept) begin
            state_q  <= state_nx;
            slots_q  <= slots_i;
            pinned_q <= pinned_i;
        end
    end

    // Pick the offset remainder, or the top slot when nothing is free.
    always_comb begin
        all_pinned = {1'b0, pinned_q} >= slots_q;
        top_slot   = slots_q - 1'b1;
        if (!done)
            index_o = '0;
        else if (all_pinned)
            index_o = top_slot[IDX_W-1:0];
        else
            index_o = rem[IDX_W-1:0] + pinned_q;
        valid_o = done;
    end
endmodule

// File: rtl/tlb_victim_sel_chk.sv
// Property checker for tlb_victim_sel. It is bound to every instance and
// observes the ports together with the captured range and generator state.
module tlb_victim_sel_chk #(
    parameter int unsigned STATE_W = 32,
    parameter int unsigned IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_i,
    input logic               busy,
    input logic [STATE_W-1:0] state_q,
    input logic [IDX_W:0]     slots_q,
    input logic [IDX_W-1:0]   pinned_q,
    input logic [IDX_W-1:0]   index_o,
    input logic               valid_o
);
    // R5: the valid strobe lasts a single cycle.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: a result appears only at the close of a busy period.
    assert_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(busy));

    // R6: the state holds whenever no request is taken.
    assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !req_i) |=> $stable(state_q));

    // R4: the index stays inside the unpinned range.
    assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ({1'b0, pinned_q} < slots_q)) |->
        (index_o >= pinned_q) && ({1'b0, index_o} < slots_q));

    // R7: with nothing free, the top slot is returned.
    assert_all_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ({1'b0, pinned_q} >= slots_q)) |->
        ({1'b0, index_o} == IDX_W'(slots_q - 1'b1)));
endmodule

bind tlb_victim_sel tlb_victim_sel_chk #(.STATE_W(STATE_W), .IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .busy     (busy),
    .state_q  (state_q),
    .slots_q  (slots_q),
    .pinned_q (pinned_q),
    .index_o  (index_o),
    .valid_o  (valid_o)
);

// File: tb/tlb_victim_sel_tb_top.sv
// Scoreboard bench: the driver pushes expected index and arrival time, and
// the monitor pops and compares them on each valid pulse.
module tlb_victim_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 17;   // negedges from request setup to valid sample

    typedef struct {
        int          idx;
        int          when;
        logic [31:0] st;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [6:0] slots_i = 7'd64;
    logic [5:0] pinned_i = 6'd0;
    logic [5:0] index_o;
    logic       valid_o;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          ncnt = 0;
    logic [31:0] model_st = 32'd0;
    exp_t        sb[$];

    tlb_victim_sel dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .slots_i  (slots_i),
        .pinned_i (pinned_i),
        .index_o  (index_o),
        .valid_o  (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_idx(input int e, input int w, input logic [31:0] st);
        int raw;
        raw = int'(st[31:16]);
        if (w >= e) return (e - 1) & 63;
        return (raw % (e - w)) + w;
    endfunction

    // Issue one accepted request and optionally disturb the busy window (R6, R8).
    task automatic send(input int e, input int w, input bit disturb);
        exp_t x;
        @(negedge clk); #1;
        slots_i  = 7'(e);
        pinned_i = 6'(w);
        req_i    = 1'b1;
        model_st = model_st * 32'd314159 + 32'd1;   // R2
        x.idx  = ref_idx(e, w, model_st);           // R3, R4, R7
        x.when = ncnt + LATENCY;                    // R5
        x.st   = model_st;
        sb.push_back(x);
        @(negedge clk); #1;
        req_i = 1'b0;
        if (disturb) begin
            slots_i  = 7'd3;
            pinned_i = 6'd1;
            repeat (2) @(negedge clk);
            #1 req_i = 1'b1;
            @(negedge clk); #1;
            req_i = 1'b0;
            slots_i = 7'd64;
            pinned_i = 6'd63;
        end
        repeat (20) @(negedge clk);
    endtask

    // Monitor: pop and compare each result; flag spurious pulses.
    initial begin
        forever begin
            @(negedge clk);
            ncnt++;
            if (rst_n && valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6 spurious valid", 1, 0);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    check(index_o == 6'(x.idx), "R4 index value", int'(index_o), x.idx);
                    check(ncnt == x.when, "R5 latency", ncnt, x.when);
                end
            end else if (rst_n) begin
                if (index_o != 6'd0) check(1'b0, "R5 idle index", int'(index_o), 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(valid_o == 1'b0, "R1 valid low in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid low after reset", int'(valid_o), 0);
        check(index_o == 6'd0, "R1 index zero after reset", int'(index_o), 0);
        send(64, 5, 1'b0);          // R1: state 1 -> index 5
        send(64, 0, 1'b0);          // R2, R3
        send(48, 8, 1'b0);          // R4
        send(16, 15, 1'b0);         // R4 span of one
        send(1, 0, 1'b0);           // R4 single slot
        send(8, 8, 1'b0);           // R7 fully pinned
        send(8, 20, 1'b0);          // R7 over-pinned
        send(40, 3, 1'b1);          // R6, R8 disturbance
        send(33, 7, 1'b1);          // R6, R8 again
        for (int i = 0; i < 24; i++) begin
            send(1 + ((i * 13 + 7) % 64), (i * 5) % 40, i[0]);
        end
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R5 all results delivered", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule